// File: doc/BRIEF.md
# Bus Firewall Domain Permission Checker

This block decides, one request at a time, whether a bus access may proceed. Every requesting master carries a small identifier. A master map turns that identifier into one of eight domains. Every target slave carries its own identifier, and a slave map turns it into one of eight groups. A permission table holds a two-bit code for each pairing of group and domain. The security state of the access picks one of the two code bits, and that bit grants or refuses the access.

Software programs all three tables through a write-only 32-bit register port. The writes land in a shadow copy, and the checker keeps using the active copy. A control register holds one bit for each firewall unit. When the bit that belongs to this unit goes from 0 to 1, the whole shadow copy moves into the active tables in one step. The upper half of each control write selects which of the lower control bits that write may change. This lets software clear the bit and then set it again without touching the bits of other units. The verdict comes out of a register one clock after the request is presented.

Top module: `fwchk_top`

## Requirements
- R1: After reset, resp_valid is 0, every master maps to domain 0, every slave maps to group 0 and the whole permission table is zero, so every in-range access is allowed.
- R2: A request presented with req_valid high at a clock edge yields resp_valid=1 and its verdict on resp_allow after that edge, back to back on consecutive cycles, and resp_valid is 0 in the cycle after req_valid was low. A request at the edge that follows a commit write uses the newly committed tables.
- R3: The domain of master m is the 4-bit field at bits (m mod 8)*4 of the domain word at register address m/8 (addresses 0x00 to 0x07).
- R4: The group of slave s is the 4-bit field at bits (s mod 5)*4 of the group word at register address 0x10 + s/5 (addresses 0x10 to 0x1F). Bits 31:20 of a group word are ignored.
- R5: The code for group g and domain d is the 2-bit field at bit d*2 + (g mod 2)*16 of the permission word at address 0x20 + g/2. Code bit 1 set refuses non-secure accesses, and code bit 0 set refuses secure accesses. So 00 allows both, 01 allows only non-secure, 10 allows only secure, and 11 allows neither.
- R6: Writes to the table addresses do not change any verdict until a commit.
- R7: A write to address 0x30 changes control bit i to wdata[i] only where wdata[16+i] is 1. A commit happens only when control bit UNIT_SEL (default 0) changes from 0 to 1. A write that leaves the bit at 1 does not commit.
- R8: Control bits other than UNIT_SEL never cause a commit. A control write with wdata[31:16] all zero leaves every control bit unchanged.
- R9: An access is refused when its slave ID is 80 or above, when the master's domain field is 8 or above, or when the slave's group field is 8 or above.
- R10: A permission word of 0xFFFFFFFF refuses every access in both of its groups, whatever the security state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Access request present |
| req_mst | input | 6 | Requesting master ID |
| req_slv | input | 7 | Target slave ID |
| req_secure | input | 1 | 1 for a secure access, 0 for a non-secure one |
| resp_valid | output | 1 | Verdict present (one cycle after the request) |
| resp_allow | output | 1 | 1 when the access is allowed |

## Verification
Directed patterns place a single master, a single slave and a single code at chosen field positions. This shows whether the packing arithmetic picks the right word and the right nibble, and whether a neighbouring master, slave or group is left untouched. Each such code is then probed in both security states, which separates the non-secure bit of the code from the secure bit. Control writes are sent in several orders:
- the bit already set,
- a different unit's bit,
- the write-enable bits cleared,
- a proper clear followed by a set.

These orders show that only a true 0-to-1 rise of this unit's bit commits, with shadow-only writes observed in between. Random tables that include out-of-range domain and group values, together with slave IDs beyond 79, are compared against an independent model of the rules.

// File: rtl/fwchk_pkg.sv
package fwchk_pkg;

    localparam int REG_W        = 32;
    localparam int ADDR_W       = 8;
    localparam int NIB_W        = 4;
    localparam int N_DOM        = 8;
    localparam int N_GRP        = 8;
    localparam int MST_PER_WORD = 8;
    localparam int SLV_PER_WORD = 5;
    localparam int GRP_USED_W   = SLV_PER_WORD * NIB_W;
    localparam int LUT_WORDS    = N_GRP / 2;
    localparam int NUM_UNITS    = 10;

    // register pages (upper address nibble) and the control address
    localparam logic [3:0]        PAGE_DOM = 4'h0;
    localparam logic [3:0]        PAGE_GRP = 4'h1;
    localparam logic [3:0]        PAGE_LUT = 4'h2;
    localparam logic [ADDR_W-1:0] CTL_ADDR = 8'h30;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_DOM,
        RK_GRP,
        RK_LUT,
        RK_CTL
    } reg_kind_e;

    typedef struct packed {
        logic valid;
        logic allow;
    } resp_t;

    // bit 1 of a code refuses non-secure traffic, bit 0 refuses secure traffic
    function automatic logic code_denies(input logic [1:0] code, input logic secure);
        return secure ? code[0] : code[1];
    endfunction

endpackage

// File: rtl/fwchk_regs.sv
module fwchk_regs
    import fwchk_pkg::*;
#(
    parameter int DOM_WORDS = 8,
    parameter int GRP_WORDS = 16,
    parameter int UNIT_SEL  = 0
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [REG_W-1:0]                     wr_data,
    output logic [DOM_WORDS-1:0][REG_W-1:0]      act_dom,
    output logic [GRP_WORDS-1:0][GRP_USED_W-1:0] act_grp,
    output logic [LUT_WORDS-1:0][REG_W-1:0]      act_lut
);

    localparam int DOM_IDX_W = $clog2(DOM_WORDS);
    localparam int GRP_IDX_W = $clog2(GRP_WORDS);
    localparam int LUT_IDX_W = $clog2(LUT_WORDS);
    localparam logic [4:0] DOM_LIM = 5'(DOM_WORDS);
    localparam logic [4:0] GRP_LIM = 5'(GRP_WORDS);
    localparam logic [4:0] LUT_LIM = 5'(LUT_WORDS);

    reg_kind_e kind;
    logic [DOM_WORDS-1:0][REG_W-1:0]      sh_dom;
    logic [GRP_WORDS-1:0][GRP_USED_W-1:0] sh_grp;
    logic [LUT_WORDS-1:0][REG_W-1:0]      sh_lut;

    logic [NUM_UNITS-1:0] ctl_q;
    logic [NUM_UNITS-1:0] ctl_nxt;
    logic [NUM_UNITS-1:0] ctl_en;
    logic                 ctl_we;
    logic                 commit_fire;

    // address decode
    always_comb begin
        kind = RK_NONE;
        if (wr_addr == CTL_ADDR)
            kind = RK_CTL;
        else if (wr_addr[7:4] == PAGE_DOM && {1'b0, wr_addr[3:0]} < DOM_LIM)
            kind = RK_DOM;
        else if (wr_addr[7:4] == PAGE_GRP && {1'b0, wr_addr[3:0]} < GRP_LIM)
            kind = RK_GRP;
        else if (wr_addr[7:4] == PAGE_LUT && {1'b0, wr_addr[3:0]} < LUT_LIM)
            kind = RK_LUT;
    end

    // masked control write and rising-edge commit detection
    assign ctl_we      = wr_en && (kind == RK_CTL);
    assign ctl_en      = wr_data[16 +: NUM_UNITS];
    assign ctl_nxt     = (ctl_q & ~ctl_en) | (wr_data[NUM_UNITS-1:0] & ctl_en);
    assign commit_fire = ctl_we && ctl_nxt[UNIT_SEL] && !ctl_q[UNIT_SEL];

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (ctl_we)
            ctl_q <= ctl_nxt;
    end

    for (genvar i = 0; i < DOM_WORDS; i++) begin : g_dom
        logic [REG_W-1:0] sh_q, act_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q  <= '0;
                act_q <= '0;
            end else begin
                if (wr_en && kind == RK_DOM && wr_addr[DOM_IDX_W-1:0] == DOM_IDX_W'(i))
                    sh_q <= wr_data;
                if (commit_fire)
                    act_q <= sh_q;
            end
        end
        assign sh_dom[i]  = sh_q;
        assign act_dom[i] = act_q;
    end

    for (genvar i = 0; i < GRP_WORDS; i++) begin : g_grp
        logic [GRP_USED_W-1:0] sh_q, act_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q  <= '0;
                act_q <= '0;
            end else begin
                if (wr_en && kind == RK_GRP && wr_addr[GRP_IDX_W-1:0] == GRP_IDX_W'(i))
                    sh_q <= wr_data[GRP_USED_W-1:0];
                if (commit_fire)
                    act_q <= sh_q;
            end
        end
        assign sh_grp[i]  = sh_q;
        assign act_grp[i] = act_q;
    end

    for (genvar i = 0; i < LUT_WORDS; i++) begin : g_lut
        logic [REG_W-1:0] sh_q, act_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q  <= '0;
                act_q <= '0;
            end else begin
                if (wr_en && kind == RK_LUT && wr_addr[LUT_IDX_W-1:0] == LUT_IDX_W'(i))
                    sh_q <= wr_data;
                if (commit_fire)
                    act_q <= sh_q;
            end
        end
        assign sh_lut[i]  = sh_q;
        assign act_lut[i] = act_q;
    end

    // active tables move only on a commit
    assert_shadow_only_R6: assert property (@(posedge clk) disable iff (rst)
        !commit_fire |=> $stable(act_dom) && $stable(act_grp) && $stable(act_lut));

    // a commit copies the whole shadow set
    assert_commit_copy_R7: assert property (@(posedge clk) disable iff (rst)
        commit_fire |=> (act_dom == $past(sh_dom)) && (act_grp == $past(sh_grp))
                        && (act_lut == $past(sh_lut)));

    // control write without enable bits changes nothing
    assert_ctl_noenable_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && wr_data[31:16] == 16'h0) |=> $stable(ctl_q));

endmodule

// File: rtl/fwchk_decide.sv
module fwchk_decide
    import fwchk_pkg::*;
#(
    parameter int MST_W     = 6,
    parameter int SLV_W     = 7,
    parameter int NUM_SLV   = 80,
    parameter int DOM_WORDS = 8,
    parameter int GRP_WORDS = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [DOM_WORDS-1:0][REG_W-1:0]      act_dom,
    input  logic [GRP_WORDS-1:0][GRP_USED_W-1:0] act_grp,
    input  logic [LUT_WORDS-1:0][REG_W-1:0]      act_lut,
    input  logic                                 req_valid,
    input  logic [MST_W-1:0]                     req_mst,
    input  logic [SLV_W-1:0]                     req_slv,
    input  logic                                 req_secure,
    output logic                                 resp_valid,
    output logic                                 resp_allow
);

    localparam int GRP_IDX_W = $clog2(GRP_WORDS);
    localparam logic [SLV_W-1:0] SPW     = SLV_W'(SLV_PER_WORD);
    localparam logic [SLV_W-1:0] SLV_LIM = SLV_W'(NUM_SLV);

    logic [REG_W-1:0]      dom_word;
    logic [NIB_W-1:0]      dom;
    logic [SLV_W-1:0]      slv_q;
    logic [SLV_W-1:0]      slv_r;
    logic                  slv_ok;
    logic [GRP_USED_W-1:0] grp_word;
    logic [NIB_W-1:0]      grp;
    logic [REG_W-1:0]      lut_word;
    logic [1:0]            code;
    logic                  deny;
    resp_t                 resp_q;
    logic                  unused_bits;

    always_comb begin
        dom_word = act_dom[req_mst[MST_W-1:3]];
        dom      = NIB_W'(dom_word >> {req_mst[2:0], 2'b00});
        slv_q    = req_slv / SPW;
        slv_r    = req_slv - slv_q * SPW;
        slv_ok   = req_slv < SLV_LIM;
        grp_word = act_grp[slv_q[GRP_IDX_W-1:0]];
        grp      = NIB_W'(grp_word >> {slv_r[2:0], 2'b00});
        lut_word = act_lut[grp[2:1]];
        code     = 2'(lut_word >> {grp[0], dom[2:0], 1'b0});
        deny     = !slv_ok || dom[3] || grp[3] || code_denies(code, req_secure);
    end

    assign unused_bits = ^{slv_q, slv_r};

    always_ff @(posedge clk) begin
        if (rst)
            resp_q <= '0;
        else
            resp_q <= '{valid: req_valid, allow: req_valid && !deny};
    end

    assign resp_valid = resp_q.valid;
    assign resp_allow = resp_q.allow;

    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    assert_resp_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid && !resp_allow);

    assert_slave_range_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_slv >= SLV_LIM) |=> resp_valid && !resp_allow);

endmodule

// File: rtl/fwchk_top.sv
module fwchk_top
    import fwchk_pkg::*;
#(
    parameter int MST_W    = 6,
    parameter int SLV_W    = 7,
    parameter int NUM_SLV  = 80,
    parameter int UNIT_SEL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic [MST_W-1:0]  req_mst,
    input  logic [SLV_W-1:0]  req_slv,
    input  logic              req_secure,
    output logic              resp_valid,
    output logic              resp_allow
);

    localparam int DOM_WORDS = (1 << MST_W) / MST_PER_WORD;
    localparam int GRP_WORDS = (NUM_SLV + SLV_PER_WORD - 1) / SLV_PER_WORD;

    logic [DOM_WORDS-1:0][REG_W-1:0]      act_dom;
    logic [GRP_WORDS-1:0][GRP_USED_W-1:0] act_grp;
    logic [LUT_WORDS-1:0][REG_W-1:0]      act_lut;

    fwchk_regs #(
        .DOM_WORDS (DOM_WORDS),
        .GRP_WORDS (GRP_WORDS),
        .UNIT_SEL  (UNIT_SEL)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .act_dom (act_dom),
        .act_grp (act_grp),
        .act_lut (act_lut)
    );

    fwchk_decide #(
        .MST_W     (MST_W),
        .SLV_W     (SLV_W),
        .NUM_SLV   (NUM_SLV),
        .DOM_WORDS (DOM_WORDS),
        .GRP_WORDS (GRP_WORDS)
    ) u_decide (
        .clk        (clk),
        .rst        (rst),
        .act_dom    (act_dom),
        .act_grp    (act_grp),
        .act_lut    (act_lut),
        .req_valid  (req_valid),
        .req_mst    (req_mst),
        .req_slv    (req_slv),
        .req_secure (req_secure),
        .resp_valid (resp_valid),
        .resp_allow (resp_allow)
    );

endmodule

// File: tb/fwchk_top_test.sv
`timescale 1ns/1ps
module fwchk_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_mst = '0;
    logic [6:0]  req_slv = '0;
    logic        req_secure = 1'b0;
    logic        resp_valid;
    logic        resp_allow;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // bench model of the register file, built from the requirements
    logic [31:0] m_sh_dom [8];
    logic [31:0] m_sh_grp [16];
    logic [31:0] m_sh_lut [4];
    logic [31:0] m_ac_dom [8];
    logic [31:0] m_ac_grp [16];
    logic [31:0] m_ac_lut [4];
    logic [15:0] m_ctl;

    always #4 clk = ~clk;

    fwchk_top uut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_mst(req_mst),
        .req_slv(req_slv), .req_secure(req_secure),
        .resp_valid(resp_valid), .resp_allow(resp_allow)
    );

    function automatic bit model_allow(int mst, int slv, bit sec);
        int dom, grp, code;
        dom = (m_ac_dom[mst / 8] >> ((mst % 8) * 4)) & 15;
        if (slv >= 80) return 0;
        grp = (m_ac_grp[slv / 5] >> ((slv % 5) * 4)) & 15;
        if (dom >= 8 || grp >= 8) return 0;
        code = (m_ac_lut[grp / 2] >> (dom * 2 + (grp % 2) * 16)) & 3;
        return sec ? ((code & 1) == 0) : ((code & 2) == 0);
    endfunction

    task automatic model_write(logic [7:0] a, logic [31:0] d);
        logic [15:0] nxt;
        if (a < 8) m_sh_dom[a] = d;
        else if (a >= 8'h10 && a < 8'h20) m_sh_grp[a - 8'h10] = d;
        else if (a >= 8'h20 && a < 8'h24) m_sh_lut[a - 8'h20] = d;
        else if (a == 8'h30) begin
            nxt = (m_ctl & ~d[31:16]) | (d[15:0] & d[31:16]);
            if (nxt[0] && !m_ctl[0]) begin
                for (int i = 0; i < 8; i++)  m_ac_dom[i] = m_sh_dom[i];
                for (int i = 0; i < 16; i++) m_ac_grp[i] = m_sh_grp[i];
                for (int i = 0; i < 4; i++)  m_ac_lut[i] = m_sh_lut[i];
            end
            m_ctl = nxt;
        end
    endtask

    task automatic reg_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic commit();
        reg_write(8'h30, 32'h0001_0000);
        reg_write(8'h30, 32'h0001_0001);
    endtask

    task automatic check_req(int mst, int slv, bit sec, bit exp, string tag);
        @(negedge clk);
        req_valid  = 1'b1;
        req_mst    = 6'(mst);
        req_slv    = 7'(slv);
        req_secure = sec;
        @(negedge clk);
        req_valid = 1'b0;
        n_checks++;
        if (resp_valid !== 1'b1 || resp_allow !== exp) begin
            n_fails++;
            $display("FAIL %s mst=%0d slv=%0d sec=%0d: valid=%b allow=%b expected valid=1 allow=%b",
                     tag, mst, slv, sec, resp_valid, resp_allow, exp);
        end
    endtask

    task automatic check_bit(logic act, logic exp, string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic clear_tables();
        for (int i = 0; i < 8; i++)  reg_write(8'(i), 32'h0);
        for (int i = 0; i < 16; i++) reg_write(8'h10 + 8'(i), 32'h0);
        for (int i = 0; i < 4; i++)  reg_write(8'h20 + 8'(i), 32'h0);
        commit();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_bit(resp_valid, 1'b0, "R1 resp_valid after reset");
        check_req(0, 0, 0, 1'b1, "R1 reset allow");
        check_req(63, 79, 1, 1'b1, "R1 reset allow far ids");
    endtask

    task automatic t_shadow();
        for (int i = 0; i < 4; i++) reg_write(8'h20 + 8'(i), 32'hFFFF_FFFF);
        check_req(0, 0, 0, 1'b1, "R6 shadow not yet active ns");
        check_req(5, 40, 1, 1'b1, "R6 shadow not yet active s");
        commit();
        check_req(0, 0, 0, 1'b0, "R10 all-ones denies ns group0");
        check_req(9, 5, 1, 1'b0, "R10 all-ones denies s group0");
        clear_tables();
        check_req(0, 0, 1, 1'b1, "R6 restored after commit");
    endtask

    task automatic t_ctl();
        reg_write(8'h20, 32'h0000_0003);          // group0 domain0 denies both
        reg_write(8'h30, 32'h0001_0001);          // bit0 already 1
        check_req(0, 0, 0, 1'b1, "R7 no commit when bit stays set");
        reg_write(8'h30, 32'h0002_0000);
        reg_write(8'h30, 32'h0002_0002);          // other unit's bit rises
        check_req(0, 0, 0, 1'b1, "R8 other unit bit no commit");
        reg_write(8'h30, 32'h0000_0000);          // clear attempt without enable
        reg_write(8'h30, 32'h0001_0001);
        check_req(0, 0, 1, 1'b1, "R8 write without enable ignored");
        commit();
        check_req(0, 0, 0, 1'b0, "R7 proper commit ns");
        check_req(0, 0, 1, 1'b0, "R7 proper commit s");
        clear_tables();
    endtask

    task automatic t_packing();
        reg_write(8'h01, 32'h0050_0000);          // master 13 -> domain 5
        reg_write(8'h14, 32'hFFF0_3000);          // slave 23 -> group 3, top bits junk
        reg_write(8'h21, 32'h0400_0000);          // group3 domain5 code 01
        commit();
        check_req(13, 23, 0, 1'b1, "R5 code01 ns allowed");
        check_req(13, 23, 1, 1'b0, "R5 code01 s denied");
        check_req(12, 23, 1, 1'b1, "R3 neighbour master domain0");
        check_req(13, 22, 1, 1'b1, "R4 neighbour slave group0");
        check_req(13, 24, 1, 1'b1, "R4 upper bits ignored slave24");
        reg_write(8'h21, 32'h0800_0000);          // code 10
        commit();
        check_req(13, 23, 0, 1'b0, "R5 code10 ns denied");
        check_req(13, 23, 1, 1'b1, "R5 code10 s allowed");
        clear_tables();
    endtask

    task automatic t_range();
        check_req(0, 80, 0, 1'b0, "R9 slave 80 denied");
        check_req(0, 127, 1, 1'b0, "R9 slave 127 denied");
        check_req(0, 79, 1, 1'b1, "R9 slave 79 allowed");
        reg_write(8'h00, 32'h0000_0009);          // master0 -> domain 9
        reg_write(8'h10, 32'h0000_000C);          // slave0 -> group 12
        commit();
        check_req(0, 1, 0, 1'b0, "R9 domain 9 denied");
        check_req(1, 0, 1, 1'b0, "R9 group 12 denied");
        check_req(1, 1, 1, 1'b1, "R9 in-range neighbour allowed");
        clear_tables();
    endtask

    task automatic t_timing();
        reg_write(8'h20, 32'h0000_0002);          // group0 domain0 denies ns
        commit();
        @(negedge clk);
        req_valid = 1'b1; req_mst = 6'd0; req_slv = 7'd0; req_secure = 1'b0;
        @(negedge clk);
        check_bit(resp_valid, 1'b1, "R2 valid first of pair");
        check_bit(resp_allow, 1'b0, "R2 deny first of pair");
        req_secure = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_bit(resp_valid, 1'b1, "R2 valid second of pair");
        check_bit(resp_allow, 1'b1, "R2 allow second of pair");
        @(negedge clk);
        check_bit(resp_valid, 1'b0, "R2 valid drops");
        clear_tables();
    endtask

    task automatic t_random();
        logic [31:0] d;
        for (int c = 0; c < 20; c++) begin
            for (int i = 0; i < 8; i++) begin
                d = $urandom;
                if (c % 3 != 0) d = d & 32'h7777_7777;
                reg_write(8'(i), d);
            end
            for (int i = 0; i < 16; i++) begin
                d = $urandom;
                if (c % 4 != 0) d = d & 32'h7777_7777;
                reg_write(8'h10 + 8'(i), d);
            end
            for (int i = 0; i < 4; i++) begin
                d = $urandom;
                if (c % 5 == 1) d = 32'h0;
                if (c % 5 == 2) d = 32'hFFFF_FFFF;
                reg_write(8'h20 + 8'(i), d);
            end
            commit();
            for (int k = 0; k < 40; k++) begin
                int mst, slv;
                bit sec;
                mst = int'($urandom % 64);
                slv = int'($urandom % 96);
                sec = 1'($urandom % 2);
                check_req(mst, slv, sec, model_allow(mst, slv, sec), "R5 random vs model");
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++)  begin m_sh_dom[i] = 0; m_ac_dom[i] = 0; end
        for (int i = 0; i < 16; i++) begin m_sh_grp[i] = 0; m_ac_grp[i] = 0; end
        for (int i = 0; i < 4; i++)  begin m_sh_lut[i] = 0; m_ac_lut[i] = 0; end
        m_ctl = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_shadow();
        t_ctl();
        t_packing();
        t_range();
        t_timing();
        t_random();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule